// File: doc/BRIEF.md
# Power-On and Warm Reset Sequencer

This block is the device-side reset controller of a chip. It watches two active-low reset inputs from the board: a cold (power-on) reset and a warm reset. It also watches a bus of strap pins that choose the boot mode and configuration. Its output, `rst_done`, goes high once the device may leave reset. Both reset inputs and the strap bus pass through two-flop synchronizers, and every time limit is counted in cycles of the one core clock.

Cold and warm release take separate paths. A cold release waits a long, parameterised delay before `rst_done` rises, and a warm release waits a short one. At each accepted release the strap pins must stay steady for a setup window before the release and a hold window after it. The block latches them into `boot_cfg` at the last cycle of the hold window and keeps that value until the next release that it accepts. The block has three sticky error flags, cleared only by cold reset:
- a warm pulse that is too short;
- a strap change inside the window;
- a warm reset that breaks its ordering against cold release.

The microsecond and millisecond limits come from a clock-frequency parameter in kHz.

Top module: `rst_release_seq`

## Requirements
- R1: `rst_done` is 0 while the cold input is low. It is 0 from the third rising clock edge after either reset input goes low, and it stays 0 while that input stays low.
- R2: When `cold_rst_n` rises and `warm_rst_n` stays high, `rst_done` is still 0 after COLD_DELAY+1 rising edges and is 1 after COLD_DELAY+2 rising edges. COLD_DELAY+2 must not exceed 21000.
- R3: When `warm_rst_n` rises after a warm pulse, `rst_done` is still 0 after WARM_DELAY+2 rising edges and is 1 after WARM_DELAY+3 rising edges. WARM_DELAY+3 must not exceed 35.
- R4: A warm low pulse shorter than WARM_MIN (24) clock cycles sets `err_warm_short`, and `boot_cfg` keeps its previous value.
- R5: A warm low pulse of WARM_MIN cycles or more is a valid request. The strap value is latched into `boot_cfg` HOLD+2 rising edges after `warm_rst_n` rises.
- R6: `boot_cfg` is 0 while the cold input is low. After a cold release it holds the strap value present at rising edge HOLD+2 after `cold_rst_n` rises.
- R7: Let a strap change happen d cycles after the accepted release, where a negative d means before it. A change with -SETUP < d < HOLD sets `err_boot_window` (SETUP = HOLD = 12). A change outside that range does not set it.
- R8: `warm_rst_n` falling fewer than PW_CYC = CLK_KHZ*1340/1000 cycles after `cold_rst_n` rose sets `err_warm_seq`. A fall at PW_CYC cycles or later does not set it.
- R9: `warm_rst_n` rising fewer than WSU_CYC = CLK_KHZ*100/1000 cycles before `cold_rst_n` rises sets `err_warm_seq`. A rise WSU_CYC cycles or more earlier does not set it.
- R10: Once set, each error flag stays set until the cold input goes low. All three flags are 0 while the cold input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all timing is counted in its cycles |
| cold_rst_n | input | 1 | Power-on reset request, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset request, active low, asynchronous |
| strap_pins | input | BOOT_W | Boot mode and configuration straps, quasi-static |
| rst_done | output | 1 | High when the device may leave reset |
| boot_cfg | output | BOOT_W | Strap value latched at the end of the last hold window |
| err_warm_short | output | 1 | Sticky: warm pulse shorter than WARM_MIN |
| err_boot_window | output | 1 | Sticky: strap change inside the setup or hold window |
| err_warm_seq | output | 1 | Sticky: warm reset too close to cold release |

## Verification
The assertions assume that the cold input is low when the run starts and stays low long enough to load the synchronizers, because every property is disabled while the synchronized cold reset is low. They also assume that the history counters for strap stability and warm-high time have been filled by the time of the first release. The bench holds `cold_rst_n` low for dozens of cycles before each cold release and keeps `warm_rst_n` high from time zero. It drives every input change at a falling clock edge, so each pin offset counted in the bench reaches the synchronized domain unchanged.

// File: rtl/rstseq_pkg.sv
// Package: shared types and cycle-count helpers for the reset sequencer.
// Assumes clock rates are given in kHz and times in microseconds.
package rstseq_pkg;

    // Release sequencer states.
    typedef enum logic [1:0] {
        SEQ_COLD  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_WLOW  = 2'd2,
        SEQ_WWAIT = 2'd3
    } seq_state_t;

    // Converts a time in microseconds to core clock cycles (rounded down).
    function automatic int unsigned us_to_cycles(input int unsigned clk_khz,
                                                 input int unsigned micros);
        return (clk_khz * micros) / 1000;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
// Module: two-flop synchronizer for a bus of asynchronous inputs.
// Assumes multi-bit inputs are quasi-static, so per-bit skew is tolerated.
// The stages have no reset; they settle within two clock edges.
module rstseq_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    // Two-stage capture of the raw inputs.
    always_ff @(posedge clk) begin
        stage1 <= din;
        stage2 <= stage1;
    end

    assign dout = stage2;

endmodule

// File: rtl/rstseq_warm_guard.sv
// Module: checks warm reset pulse width and warm/cold ordering.
// Assumes synchronized inputs. Synchronous active-low reset by the
// synchronized cold reset, except for the warm-high history counter,
// which must keep running while cold reset is held low.
module rstseq_warm_guard #(
    parameter int unsigned WARM_MIN = 24,
    parameter int unsigned WSU_CYC  = 10000,
    parameter int unsigned PW_CYC   = 134000
) (
    input  logic clk,
    input  logic cold_s,
    input  logic warm_s,
    output logic cold_rise,
    output logic warm_rel_ok,
    output logic err_short,
    output logic err_seq
);

    localparam int unsigned LOW_W = $clog2(WARM_MIN + 1);
    localparam int unsigned WSU_W = $clog2(WSU_CYC + 1);
    localparam int unsigned PW_W  = $clog2(PW_CYC + 1);

    logic             cold_d;
    logic             warm_d;
    logic [LOW_W-1:0] low_cnt;
    logic [WSU_W-1:0] high_cnt;
    logic [PW_W-1:0]  since_cold;
    logic             warm_rise;
    logic             warm_fall;
    logic             low_enough;

    assign cold_rise   = cold_s & ~cold_d;
    assign warm_rise   = cold_s & warm_s & ~warm_d;
    assign warm_fall   = cold_s & ~warm_s & warm_d;
    assign low_enough  = (low_cnt >= LOW_W'(WARM_MIN));
    assign warm_rel_ok = warm_rise & low_enough;

    // Cycles the warm input has been high; runs through cold reset.
    always_ff @(posedge clk) begin
        if (!warm_s) begin
            high_cnt <= '0;
        end else if (high_cnt < WSU_W'(WSU_CYC)) begin
            high_cnt <= high_cnt + 1'b1;
        end
    end

    // Pulse-width and ordering checks with sticky error flags.
    always_ff @(posedge clk) begin
        if (!cold_s) begin
            cold_d     <= 1'b0;
            warm_d     <= warm_s;
            low_cnt    <= '0;
            since_cold <= '0;
            err_short  <= 1'b0;
            err_seq    <= 1'b0;
        end else begin
            cold_d <= 1'b1;
            warm_d <= warm_s;
            if (!warm_s) begin
                if (!low_enough) begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end else begin
                low_cnt <= '0;
            end
            if (since_cold < PW_W'(PW_CYC)) begin
                since_cold <= since_cold + 1'b1;
            end
            if (warm_rise && !low_enough) begin
                err_short <= 1'b1;
            end
            if (warm_fall && (since_cold < PW_W'(PW_CYC))) begin
                err_seq <= 1'b1;
            end
            if (cold_rise && (high_cnt < WSU_W'(WSU_CYC))) begin
                err_seq <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rstseq_strap_window.sv
// Module: strap setup/hold window checker and boot configuration latch.
// Assumes synchronized straps with the same latency as the reset inputs.
// The stability history runs without reset so that setup is measurable
// at cold release; the other state resets with the cold reset.
module rstseq_strap_window #(
    parameter int unsigned BOOT_W = 16,
    parameter int unsigned SETUP  = 12,
    parameter int unsigned HOLD   = 12
) (
    input  logic              clk,
    input  logic              cold_s,
    input  logic [BOOT_W-1:0] strap_s,
    input  logic              release_ev,
    output logic [BOOT_W-1:0] boot_cfg,
    output logic              err_window,
    output logic              hold_act
);

    localparam int unsigned STB_W = $clog2(SETUP + 1);
    localparam int unsigned HLD_W = $clog2(HOLD);

    logic [BOOT_W-1:0] strap_d;
    logic [STB_W-1:0]  stable_cnt;
    logic [STB_W-1:0]  stable_eff;
    logic [HLD_W-1:0]  hold_cnt;
    logic              changed;

    assign changed    = (strap_s != strap_d);
    assign stable_eff = changed ? '0 : stable_cnt;

    // Cycles since the last strap change, saturating at SETUP.
    always_ff @(posedge clk) begin
        strap_d <= strap_s;
        if (stable_eff < STB_W'(SETUP)) begin
            stable_cnt <= stable_eff + 1'b1;
        end else begin
            stable_cnt <= stable_eff;
        end
    end

    // Setup check at release, hold check after it, latch at window end.
    always_ff @(posedge clk) begin
        if (!cold_s) begin
            hold_act   <= 1'b0;
            hold_cnt   <= '0;
            boot_cfg   <= '0;
            err_window <= 1'b0;
        end else if (release_ev) begin
            hold_act <= 1'b1;
            hold_cnt <= HLD_W'(1);
            if (stable_eff < STB_W'(SETUP)) begin
                err_window <= 1'b1;
            end
        end else if (hold_act) begin
            if (changed) begin
                err_window <= 1'b1;
            end
            if (hold_cnt == HLD_W'(HOLD - 1)) begin
                boot_cfg <= strap_s;
                hold_act <= 1'b0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rstseq_release_fsm.sv
// Module: counts the cold and warm release delays and drives rst_done.
// Assumes synchronized inputs; synchronous active-low reset by cold_s.
// A warm assertion at any point returns the sequence to the warm-low state.
module rstseq_release_fsm
    import rstseq_pkg::*;
#(
    parameter int unsigned COLD_DELAY = 20000,
    parameter int unsigned WARM_DELAY = 20
) (
    input  logic clk,
    input  logic cold_s,
    input  logic warm_s,
    output logic done
);

    localparam int unsigned MAXD  = (COLD_DELAY > WARM_DELAY) ? COLD_DELAY : WARM_DELAY;
    localparam int unsigned CNT_W = $clog2(MAXD + 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    // State and delay counter update.
    always_ff @(posedge clk) begin
        if (!cold_s) begin
            state <= SEQ_COLD;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_COLD: begin
                    if (!warm_s) begin
                        state <= SEQ_WLOW;
                        cnt   <= '0;
                    end else if (cnt == CNT_W'(COLD_DELAY - 1)) begin
                        state <= SEQ_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_RUN: begin
                    if (!warm_s) begin
                        state <= SEQ_WLOW;
                    end
                end
                SEQ_WLOW: begin
                    if (warm_s) begin
                        state <= SEQ_WWAIT;
                        cnt   <= '0;
                    end
                end
                default: begin
                    if (!warm_s) begin
                        state <= SEQ_WLOW;
                    end else if (cnt == CNT_W'(WARM_DELAY - 1)) begin
                        state <= SEQ_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign done = (state == SEQ_RUN);

endmodule

// File: rtl/rst_release_seq.sv
// Module: top of the power-on and warm reset sequencer.
// Assumes all inputs are asynchronous to clk and the straps are
// quasi-static. Cycle limits are derived from CLK_KHZ.
module rst_release_seq
    import rstseq_pkg::*;
#(
    parameter int unsigned CLK_KHZ    = 100000,
    parameter int unsigned BOOT_W     = 16,
    parameter int unsigned COLD_DELAY = 20000,
    parameter int unsigned WARM_DELAY = 20,
    parameter int unsigned WARM_MIN   = 24,
    parameter int unsigned SETUP      = 12,
    parameter int unsigned HOLD       = 12
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              warm_rst_n,
    input  logic [BOOT_W-1:0] strap_pins,
    output logic              rst_done,
    output logic [BOOT_W-1:0] boot_cfg,
    output logic              err_warm_short,
    output logic              err_boot_window,
    output logic              err_warm_seq
);

    localparam int unsigned WSU_CYC = us_to_cycles(CLK_KHZ, 100);
    localparam int unsigned PW_CYC  = us_to_cycles(CLK_KHZ, 1340);
    localparam int unsigned SYNC_W  = BOOT_W + 2;

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic              cold_s;
    logic              warm_s;
    logic [BOOT_W-1:0] strap_s;
    logic              cold_rise;
    logic              warm_rel_ok;
    logic              hold_act;

    assign raw_bus = {cold_rst_n, warm_rst_n, strap_pins};
    assign cold_s  = sync_bus[SYNC_W-1];
    assign warm_s  = sync_bus[SYNC_W-2];
    assign strap_s = sync_bus[BOOT_W-1:0];

    rstseq_sync #(.WIDTH(SYNC_W)) i_sync (
        .clk  (clk),
        .din  (raw_bus),
        .dout (sync_bus)
    );

    rstseq_warm_guard #(
        .WARM_MIN (WARM_MIN),
        .WSU_CYC  (WSU_CYC),
        .PW_CYC   (PW_CYC)
    ) i_guard (
        .clk         (clk),
        .cold_s      (cold_s),
        .warm_s      (warm_s),
        .cold_rise   (cold_rise),
        .warm_rel_ok (warm_rel_ok),
        .err_short   (err_warm_short),
        .err_seq     (err_warm_seq)
    );

    rstseq_strap_window #(
        .BOOT_W (BOOT_W),
        .SETUP  (SETUP),
        .HOLD   (HOLD)
    ) i_window (
        .clk        (clk),
        .cold_s     (cold_s),
        .strap_s    (strap_s),
        .release_ev (cold_rise | warm_rel_ok),
        .boot_cfg   (boot_cfg),
        .err_window (err_boot_window),
        .hold_act   (hold_act)
    );

    rstseq_release_fsm #(
        .COLD_DELAY (COLD_DELAY),
        .WARM_DELAY (WARM_DELAY)
    ) i_fsm (
        .clk    (clk),
        .cold_s (cold_s),
        .warm_s (warm_s),
        .done   (rst_done)
    );

endmodule

// File: rtl/rstseq_checker.sv
// Module: property checker for rst_release_seq, attached by bind.
// Assumes the synchronized cold reset is low at time zero.
module rstseq_checker #(
    parameter int unsigned BOOT_W = 16
) (
    input logic              clk,
    input logic              cold_s,
    input logic              warm_s,
    input logic              done,
    input logic [BOOT_W-1:0] cfg,
    input logic              hold_act,
    input logic              e_short,
    input logic              e_win,
    input logic              e_seq
);

    // R1: a low warm input forces rst_done low on the next cycle.
    assert_drop_on_warm_R1: assert property (@(posedge clk) disable iff (!cold_s)
        !warm_s |=> !done);

    // R1: rst_done is only high when warm was high the cycle before.
    assert_done_needs_warm_R1: assert property (@(posedge clk) disable iff (!cold_s)
        done |-> $past(warm_s));

    // R4: the short-pulse flag rises only right after a warm release.
    assert_short_on_release_R4: assert property (@(posedge clk) disable iff (!cold_s)
        $rose(e_short) |-> ($past(warm_s) && !$past(warm_s, 2)));

    // R6: boot_cfg changes only out of an open hold window.
    assert_cfg_stable_R6: assert property (@(posedge clk) disable iff (!cold_s)
        !hold_act |=> $stable(cfg));

    // R10: error flags are sticky while cold reset stays released.
    assert_sticky_short_R10: assert property (@(posedge clk) disable iff (!cold_s)
        e_short |=> e_short);
    assert_sticky_win_R10: assert property (@(posedge clk) disable iff (!cold_s)
        e_win |=> e_win);
    assert_sticky_seq_R10: assert property (@(posedge clk) disable iff (!cold_s)
        e_seq |=> e_seq);

endmodule

bind rst_release_seq rstseq_checker #(.BOOT_W(BOOT_W)) i_rstseq_checker (
    .clk      (clk),
    .cold_s   (cold_s),
    .warm_s   (warm_s),
    .done     (rst_done),
    .cfg      (boot_cfg),
    .hold_act (hold_act),
    .e_short  (err_warm_short),
    .e_win    (err_boot_window),
    .e_seq    (err_warm_seq)
);

// File: tb/test_rst_release_seq.sv
// Bench: directed corners plus seeded random sequences for rst_release_seq.
module test_rst_release_seq;

    localparam int CLK_KHZ = 200;
    localparam int BW      = 16;
    localparam int COLD    = 150;
    localparam int WARM    = 20;
    localparam int WMIN    = 24;
    localparam int SETUP   = 12;
    localparam int HOLD    = 12;
    localparam int T_WSU   = CLK_KHZ * 100 / 1000;
    localparam int T_PW    = CLK_KHZ * 1340 / 1000;

    logic          clk = 1'b0;
    logic          cold_rst_n = 1'b0;
    logic          warm_rst_n = 1'b1;
    logic [BW-1:0] strap_pins = '0;
    logic          rst_done;
    logic [BW-1:0] boot_cfg;
    logic          err_warm_short;
    logic          err_boot_window;
    logic          err_warm_seq;

    int            n_chk = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;
    logic [BW-1:0] exp_cfg = '0;
    bit            exp_short = 1'b0;
    bit            exp_win = 1'b0;
    bit            exp_seq = 1'b0;

    always #5 clk = ~clk;

    rst_release_seq #(
        .CLK_KHZ    (CLK_KHZ),
        .BOOT_W     (BW),
        .COLD_DELAY (COLD),
        .WARM_DELAY (WARM),
        .WARM_MIN   (WMIN),
        .SETUP      (SETUP),
        .HOLD       (HOLD)
    ) i_rst_release_seq (
        .clk             (clk),
        .cold_rst_n      (cold_rst_n),
        .warm_rst_n      (warm_rst_n),
        .strap_pins      (strap_pins),
        .rst_done        (rst_done),
        .boot_cfg        (boot_cfg),
        .err_warm_short  (err_warm_short),
        .err_boot_window (err_boot_window),
        .err_warm_seq    (err_warm_seq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic bit win_err(input int d);
        return (d > -SETUP) && (d < HOLD);
    endfunction

    task automatic check_flags(input string tag);
        check({tag, " R4 err_warm_short"}, int'(err_warm_short), int'(exp_short));
        check({tag, " R7 err_boot_window"}, int'(err_boot_window), int'(exp_win));
        check({tag, " R8/R9 err_warm_seq"}, int'(err_warm_seq), int'(exp_seq));
    endtask

    // Cold cycle: straps change d cycles from release; wsu >= 0 places a
    // warm pulse ending wsu cycles before release.
    task automatic cold_cycle(input logic [BW-1:0] oldv, input logic [BW-1:0] newv,
                              input int d, input int wsu);
        cold_rst_n = 1'b0;
        strap_pins = oldv;
        tick(3);
        check("R1 done low after cold low", int'(rst_done), 0);
        tick(40);
        check("R6 boot_cfg zero in reset", int'(boot_cfg), 0);
        check("R10 flags clear in reset",
              int'({err_warm_short, err_boot_window, err_warm_seq}), 0);
        exp_short = 1'b0;
        exp_win   = win_err(d);
        exp_seq   = (wsu >= 0) && (wsu < T_WSU);
        exp_cfg   = (d <= HOLD - 1) ? newv : oldv;
        if (wsu >= 0) begin
            warm_rst_n = 1'b0;
            tick(5);
            warm_rst_n = 1'b1;
            tick(wsu);
        end
        if (d < 0) begin
            strap_pins = newv;
            tick(-d);
        end
        cold_rst_n = 1'b1;
        if (d == 0) strap_pins = newv;
        for (int e = 1; e <= COLD + 2; e++) begin
            tick(1);
            if (e == d) strap_pins = newv;
            if (e == HOLD + 2) check("R6 boot_cfg after cold release", int'(boot_cfg), int'(exp_cfg));
            if (e == COLD + 1) check("R2 done still low", int'(rst_done), 0);
            if (e == COLD + 2) check("R2 done high", int'(rst_done), 1);
        end
        check_flags("cold");
    endtask

    // Warm pulse of the given width; since = cycles from cold release at call.
    task automatic warm_pulse(input int width, input logic [BW-1:0] newv, input int since);
        strap_pins = newv;
        tick(20);
        if (since + 20 < T_PW) exp_seq = 1'b1;
        warm_rst_n = 1'b0;
        tick(3);
        check("R1 done low after warm low", int'(rst_done), 0);
        tick(width - 3);
        warm_rst_n = 1'b1;
        if (width < WMIN) exp_short = 1'b1;
        else exp_cfg = newv;
        tick(WARM + 2);
        check("R3 done still low", int'(rst_done), 0);
        tick(1);
        check("R3 done high", int'(rst_done), 1);
        check("R4/R5 boot_cfg after warm", int'(boot_cfg), int'(exp_cfg));
        check_flags("warm");
    endtask

    initial begin
        void'($urandom(32'd1357));
        tick(5);
        check("R1 reset state done", int'(rst_done), 0);
        check("R6 reset state boot_cfg", int'(boot_cfg), 0);
        check("R10 reset state flags",
              int'({err_warm_short, err_boot_window, err_warm_seq}), 0);

        // Directed: clean cold release, valid and short warm pulses.
        cold_cycle(16'h1234, 16'hA5C3, -30, -1);
        tick(T_PW);
        warm_pulse(30, 16'h0F0F, T_PW + COLD + 2);
        warm_pulse(WMIN, 16'h3C3C, T_PW + COLD + 2);
        warm_pulse(WMIN - 1, 16'h7777, T_PW + COLD + 2);

        // Directed: strap window edges (R7).
        cold_cycle(16'h0001, 16'h8000, 0, -1);
        cold_cycle(16'h0002, 16'h4000, -SETUP, -1);
        cold_cycle(16'h0003, 16'h2000, -SETUP + 1, -1);
        cold_cycle(16'h0004, 16'h1000, HOLD - 1, -1);
        cold_cycle(16'h0005, 16'h0800, HOLD, -1);

        // Directed: warm high too briefly before cold release (R9).
        cold_cycle(16'h00AA, 16'h5500, 50, T_WSU - 1);
        cold_cycle(16'h00AB, 16'h5600, 50, T_WSU);

        // Directed: warm asserted near the end of the quiet period (R8).
        cold_cycle(16'h0101, 16'h0202, -20, -1);
        tick(T_PW - 21 - (COLD + 2));
        warm_pulse(30, 16'h0303, T_PW - 21);
        cold_cycle(16'h0404, 16'h0505, -20, -1);
        tick(T_PW - 20 - (COLD + 2));
        warm_pulse(30, 16'h0606, T_PW - 20);

        // Random sequences.
        for (int it = 0; it < 30; it++) begin
            logic [BW-1:0] a;
            logic [BW-1:0] b;
            int            d;
            int            g;
            a = BW'($urandom());
            b = a ^ BW'($urandom_range(16'hFFFF, 1));
            d = int'($urandom_range(40, 0)) - 20;
            g = int'($urandom_range(150, 0));
            cold_cycle(a, b, d, -1);
            tick(g);
            warm_pulse(int'($urandom_range(40, 4)), BW'($urandom()), COLD + 2 + g);
            tick(T_PW);
            warm_pulse(int'($urandom_range(40, 4)), BW'($urandom()), T_PW);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule